// File: doc/BRIEF.md
# Card Reader Timing Wheel with Feed Freeze

This block stands in for the rotating timing mechanism of a card reader whose cards actually come from a word buffer. A buffer is filled by a separate physical reader. A free-running angle counter stands for the wheel. Three feed cam pulses are decoded from fixed angle windows once per revolution. A column emitter train runs during the card-read arc of every feed cycle. A pre-read station lever signal and twelve photocell row outputs are driven at the angles where a real card would cover or uncover them. The downstream controller samples these outputs at cam times, so each output is tied to wheel angle and not to buffer events.

The wheel may stall at one gate angle only. This gate lies after the third cam and after the post-cam check window. The wheel stalls there when a feed is commanded, a physical card is ready and the buffer holds no card. It resumes on the physical reader's read-complete pulse. A runout with no card keeps the wheel and cams turning. Faults pending from the physical reader are replayed as the controller would see them: a read fault corrupts the last column inside its emitter pulse, and a feed fault darkens every cell at the second cam.

Top module: `feed_wheel`

## Requirements
- R1: The angle counts 0..32767 and wraps, one step per clock. A tick for d degrees is d*32768/360, truncated. Cam outputs are registered, one clock after the angle: cb1 is high for ticks [910,1820), cb2 for [19569,20480), cb3 for [25486,26396). At most one cam is high at a time, and the cams run on every revolution, runouts included.
- R2: On a feed cycle, the column arc starts at tick 2730 and has 80 periods of 157 ticks. In each period, emit is high for phases 20..31. This gives exactly 80 emitter pulses, each 12 clocks wide. A cycle that was not commanded to feed has no emitter pulses.
- R3: The gate tick is 27396, which is the end of cb3 plus a 1000-tick check window. When the angle is at the gate, the wheel holds there if it is already frozen, or if feed_mag, card_ready and not fifo_full are all true at that moment. While frozen, no cam, emitter or pop output is high. With card_ready low, the wheel does not hold.
- R4: A read_done pulse at the gate releases a freeze, and the angle advances on that same edge. Leaving the gate starts a cycle. It captures feed_mag as the feed flag, the current lever as the card-present flag, and rderr_pend and fderr_pend as the replay flags.
- R5: In a feed cycle, lever drops at tick 2275, when the outgoing card clears the station. Lever rises at tick 19205 only if fifo_full is high then. It never rises in a runout with an empty buffer.
- R6: On a feed cycle that started with a card present, each column latches fifo_word at phase 12, which is 8 ticks before the emitter rises. cells shows the bitwise inverse of that word (data 1 = hole = light = cell 0) from phase 12 through phase 32. fifo_pop is high for one clock at phase 32, after the emitter falls. There are no pops and no data on other cycles.
- R7: On a card-present feed cycle, cell 0 alone is dark (cells = 0x001) from tick 2457 up to the column arc.
- R8: A captured read fault on a card-present cycle XORs cells with 0x0A5 in the last column, from phase 21 through phase 32. Without a card present, the fault has no effect and cells stay 0.
- R9: A captured feed fault on a feed cycle sets all twelve cells dark throughout the cb2 window.
- R10: After reset the angle sits at the gate and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| feed_mag | input | 1 | Feed magnets energised (feed commanded) |
| card_ready | input | 1 | Physical reader has a card ready to read |
| fifo_full | input | 1 | Buffer holds a loaded card |
| read_done | input | 1 | Physical reader finished a read cycle (pulse) |
| rderr_pend | input | 1 | Physical read fault awaiting replay |
| fderr_pend | input | 1 | Physical feed fault awaiting replay |
| fifo_word | input | 12 | Head word of the buffer, one column |
| cb1 | output | 1 | First feed cam pulse |
| cb2 | output | 1 | Second feed cam pulse |
| cb3 | output | 1 | Third feed cam pulse |
| emit | output | 1 | Column emitter |
| lever | output | 1 | Pre-read station card lever / photocell dark |
| cells | output | 12 | Read photocells, 1 = dark |
| fifo_pop | output | 1 | Consume the buffer head word |

## Verification
The bench targets four things. It checks a run-in freeze that must hold at the gate, leaving every output silent, until read_done arrives. A design that froze at the wrong angle or ignored the release would shift or lose cams. It checks a runout with no physical card, where a wrongly frozen wheel would starve the controller of cb1 and cb2. It checks column data timing: data latched on the emitter edge instead of eight ticks ahead, or a pop placed before the fall, would differ from the per-clock reference. It checks fault replay: the read-fault XOR must appear only inside the last column's pulse and only when a card was present, and the feed fault must darken all cells only during cb2.

// File: rtl/wheel_pkg.sv
package wheel_pkg;
    localparam int ROWS = 12;
    typedef logic [ROWS-1:0] row_t;

    // flags captured as the wheel leaves the gate
    typedef struct packed {
        logic feed;
        logic read;
        logic rderr;
        logic fderr;
    } cyc_t;

    function automatic int deg_to_tick(int deg, int rev);
        return (deg * rev) / 360;
    endfunction
endpackage

// File: rtl/wheel_drive.sv
module wheel_drive
    import wheel_pkg::*;
#(
    parameter int REV  = 32768,
    parameter int GATE = 27396,
    localparam int AW  = $clog2(REV)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          feed_mag,
    input  logic          card_ready,
    input  logic          fifo_full,
    input  logic          read_done,
    input  logic          rderr_pend,
    input  logic          fderr_pend,
    input  logic          lever,
    output logic [AW-1:0] angle,
    output cyc_t          cyc,
    output logic          frozen,
    output logic          adv
);
    typedef struct packed {
        logic [AW-1:0] angle;
        logic          frozen;
        cyc_t          cyc;
    } st_t;

    st_t  st_q, st_d;
    logic at_gate, hold;

    always_comb begin
        st_d    = st_q;
        at_gate = (int'(st_q.angle) == GATE);
        hold    = at_gate && (st_q.frozen || (feed_mag && card_ready && !fifo_full))
                  && !read_done;
        if (hold) begin
            st_d.frozen = 1'b1;
        end else begin
            st_d.frozen = 1'b0;
            st_d.angle  = (int'(st_q.angle) == REV - 1) ? '0 : st_q.angle + 1'b1;
            if (at_gate) begin
                st_d.cyc.feed  = feed_mag;
                st_d.cyc.read  = lever;
                st_d.cyc.rderr = rderr_pend;
                st_d.cyc.fderr = fderr_pend;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{angle: AW'(GATE), frozen: 1'b0, cyc: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign angle  = st_q.angle;
    assign cyc    = st_q.cyc;
    assign frozen = st_q.frozen;
    assign adv    = !hold;
endmodule

// File: rtl/wheel_station.sv
module wheel_station
    import wheel_pkg::*;
#(
    parameter int REV     = 32768,
    parameter int CB1_ON  = 910,
    parameter int CB1_OFF = 1820,
    parameter int CB2_ON  = 19569,
    parameter int CB2_OFF = 20480,
    parameter int CB3_ON  = 25486,
    parameter int CB3_OFF = 26396,
    parameter int LIGHT_T = 2275,
    parameter int DARK_T  = 19205,
    localparam int AW     = $clog2(REV)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] angle,
    input  logic          cyc_feed,
    input  logic          fifo_full,
    output logic [2:0]    cam,
    output logic          lever
);
    localparam int CAM_ON  [3] = '{CB1_ON, CB2_ON, CB3_ON};
    localparam int CAM_OFF [3] = '{CB1_OFF, CB2_OFF, CB3_OFF};

    typedef struct packed {
        logic [2:0] cam;
        logic       lever;
    } st_t;

    st_t        st_q, st_d;
    logic [2:0] cam_win;

    for (genvar i = 0; i < 3; i++) begin : g_cam
        assign cam_win[i] = (int'(angle) >= CAM_ON[i]) && (int'(angle) < CAM_OFF[i]);
    end

    always_comb begin
        st_d     = st_q;
        st_d.cam = cam_win;
        if (cyc_feed && int'(angle) == LIGHT_T) st_d.lever = 1'b0;
        if (cyc_feed && int'(angle) == DARK_T && fifo_full) st_d.lever = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cam   = st_q.cam;
    assign lever = st_q.lever;
endmodule

// File: rtl/wheel_columns.sv
module wheel_columns
    import wheel_pkg::*;
#(
    parameter int   REV     = 32768,
    parameter int   COL0    = 2730,
    parameter int   ANYD_T  = 2457,
    parameter int   CB2_ON  = 19569,
    parameter int   CB2_OFF = 20480,
    parameter int   COLS    = 80,
    parameter int   PER     = 157,
    parameter int   E_ON    = 20,
    parameter int   E_HIGH  = 12,
    parameter int   SETUP   = 8,
    parameter row_t MASK    = 12'h0A5,
    localparam int  AW      = $clog2(REV)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] angle,
    input  logic          adv,
    input  cyc_t          cyc,
    input  row_t          fifo_word,
    output logic          emit,
    output logic          pop,
    output row_t          cells
);
    localparam int COL_END = COL0 + COLS * PER;
    localparam int LATCH   = E_ON - SETUP;
    localparam int E_OFF   = E_ON + E_HIGH;
    localparam int PW      = $clog2(PER);
    localparam int CW      = $clog2(COLS);

    typedef struct packed {
        logic [PW-1:0] ph;
        logic [CW-1:0] col;
        logic          emit;
        logic          pop;
        row_t          cells;
        row_t          word;
    } st_t;

    st_t  st_q, st_d;
    logic in_arc, incol, reading;
    int   nxt;

    always_comb begin
        st_d    = st_q;
        in_arc  = (int'(angle) >= COL0) && (int'(angle) < COL_END);
        incol   = cyc.feed && in_arc;
        reading = incol && cyc.read;
        nxt     = (int'(angle) == REV - 1) ? 0 : int'(angle) + 1;

        // phase / column follow the angle they belong to
        if (adv) begin
            if (nxt == COL0) begin
                st_d.ph  = '0;
                st_d.col = '0;
            end else if (in_arc) begin
                if (int'(st_q.ph) == PER - 1) begin
                    st_d.ph  = '0;
                    st_d.col = st_q.col + 1'b1;
                end else begin
                    st_d.ph = st_q.ph + 1'b1;
                end
            end
        end

        st_d.emit = incol && (int'(st_q.ph) >= E_ON) && (int'(st_q.ph) < E_OFF);
        st_d.pop  = reading && (int'(st_q.ph) == E_OFF);
        if (reading && int'(st_q.ph) == LATCH) st_d.word = fifo_word;

        st_d.cells = '0;
        if (cyc.feed && cyc.read && int'(angle) >= ANYD_T && int'(angle) < COL0)
            st_d.cells[0] = 1'b1;
        if (reading && int'(st_q.ph) >= LATCH && int'(st_q.ph) <= E_OFF) begin
            st_d.cells = ~st_d.word;
            if (cyc.rderr && int'(st_q.col) == COLS - 1 && int'(st_q.ph) > E_ON)
                st_d.cells = st_d.cells ^ MASK;
        end
        if (cyc.feed && cyc.fderr && int'(angle) >= CB2_ON && int'(angle) < CB2_OFF)
            st_d.cells = '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign emit  = st_q.emit;
    assign pop   = st_q.pop;
    assign cells = st_q.cells;
endmodule

// File: rtl/feed_wheel.sv
module feed_wheel
    import wheel_pkg::*;
#(
    parameter int   REV_TICKS   = 32768,
    parameter int   CB1_ON_DEG  = 10,
    parameter int   CB1_OFF_DEG = 20,
    parameter int   CB2_ON_DEG  = 215,
    parameter int   CB2_OFF_DEG = 225,
    parameter int   CB3_ON_DEG  = 280,
    parameter int   CB3_OFF_DEG = 290,
    parameter int   LIGHT_DEG   = 25,
    parameter int   ANYD_DEG    = 27,
    parameter int   COL0_DEG    = 30,
    parameter int   DARK_DEG    = 211,
    parameter int   CHECK_TICKS = 1000,
    parameter int   COLS        = 80,
    parameter int   EMIT_PERIOD = 157,
    parameter int   EMIT_ON     = 20,
    parameter int   EMIT_HIGH   = 12,
    parameter int   SETUP_TICKS = 8,
    parameter row_t RDERR_MASK  = 12'h0A5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        feed_mag,
    input  logic        card_ready,
    input  logic        fifo_full,
    input  logic        read_done,
    input  logic        rderr_pend,
    input  logic        fderr_pend,
    input  logic [11:0] fifo_word,
    output logic        cb1,
    output logic        cb2,
    output logic        cb3,
    output logic        emit,
    output logic        lever,
    output logic [11:0] cells,
    output logic        fifo_pop
);
    localparam int AW      = $clog2(REV_TICKS);
    localparam int CB1_ON  = deg_to_tick(CB1_ON_DEG, REV_TICKS);
    localparam int CB1_OFF = deg_to_tick(CB1_OFF_DEG, REV_TICKS);
    localparam int CB2_ON  = deg_to_tick(CB2_ON_DEG, REV_TICKS);
    localparam int CB2_OFF = deg_to_tick(CB2_OFF_DEG, REV_TICKS);
    localparam int CB3_ON  = deg_to_tick(CB3_ON_DEG, REV_TICKS);
    localparam int CB3_OFF = deg_to_tick(CB3_OFF_DEG, REV_TICKS);
    localparam int LIGHT_T = deg_to_tick(LIGHT_DEG, REV_TICKS);
    localparam int ANYD_T  = deg_to_tick(ANYD_DEG, REV_TICKS);
    localparam int COL0_T  = deg_to_tick(COL0_DEG, REV_TICKS);
    localparam int DARK_T  = deg_to_tick(DARK_DEG, REV_TICKS);
    localparam int GATE_T  = CB3_OFF + CHECK_TICKS;

    logic [AW-1:0] angle;
    cyc_t          cyc;
    logic          frozen, adv;
    logic [2:0]    cam;

    wheel_drive #(.REV(REV_TICKS), .GATE(GATE_T)) u_drive (
        .clk(clk), .rst_n(rst_n), .feed_mag(feed_mag), .card_ready(card_ready),
        .fifo_full(fifo_full), .read_done(read_done), .rderr_pend(rderr_pend),
        .fderr_pend(fderr_pend), .lever(lever), .angle(angle), .cyc(cyc),
        .frozen(frozen), .adv(adv)
    );

    wheel_station #(
        .REV(REV_TICKS), .CB1_ON(CB1_ON), .CB1_OFF(CB1_OFF), .CB2_ON(CB2_ON),
        .CB2_OFF(CB2_OFF), .CB3_ON(CB3_ON), .CB3_OFF(CB3_OFF),
        .LIGHT_T(LIGHT_T), .DARK_T(DARK_T)
    ) u_station (
        .clk(clk), .rst_n(rst_n), .angle(angle), .cyc_feed(cyc.feed),
        .fifo_full(fifo_full), .cam(cam), .lever(lever)
    );

    wheel_columns #(
        .REV(REV_TICKS), .COL0(COL0_T), .ANYD_T(ANYD_T), .CB2_ON(CB2_ON),
        .CB2_OFF(CB2_OFF), .COLS(COLS), .PER(EMIT_PERIOD), .E_ON(EMIT_ON),
        .E_HIGH(EMIT_HIGH), .SETUP(SETUP_TICKS), .MASK(RDERR_MASK)
    ) u_columns (
        .clk(clk), .rst_n(rst_n), .angle(angle), .adv(adv), .cyc(cyc),
        .fifo_word(fifo_word), .emit(emit), .pop(fifo_pop), .cells(cells)
    );

    assign cb1 = cam[0];
    assign cb2 = cam[1];
    assign cb3 = cam[2];
endmodule

// File: rtl/feed_wheel_chk.sv
module feed_wheel_chk #(
    parameter int EMIT_HIGH = 12
) (
    input logic clk,
    input logic rst_n,
    input logic cb1,
    input logic cb2,
    input logic cb3,
    input logic emit,
    input logic fifo_pop,
    input logic lever,
    input logic fifo_full,
    input logic read_done,
    input logic frozen
);
    int hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    hi_cnt <= 0;
        else if (emit) hi_cnt <= hi_cnt + 1;
        else           hi_cnt <= 0;
    end

    // R1
    cam_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cb1, cb2, cb3}));

    // R2
    emit_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(emit) |-> hi_cnt == EMIT_HIGH);

    // R6
    pop_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_pop |-> (!emit && $past(emit)));

    // R3
    frozen_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |-> !(cb1 || cb2 || cb3 || emit || fifo_pop));

    // R4
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && read_done) |=> !frozen);

    // R5
    lever_needs_card_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lever) |-> $past(fifo_full));
endmodule

bind feed_wheel feed_wheel_chk #(.EMIT_HIGH(EMIT_HIGH)) u_chk (
    .clk(clk), .rst_n(rst_n), .cb1(cb1), .cb2(cb2), .cb3(cb3), .emit(emit),
    .fifo_pop(fifo_pop), .lever(lever), .fifo_full(fifo_full),
    .read_done(read_done), .frozen(frozen)
);

// File: tb/tb_feed_wheel.sv
module tb_feed_wheel;
    localparam int CLK_PERIOD = 10;
    localparam int REV   = 32768;
    localparam int CB1A  = 10 * REV / 360,  CB1B = 20 * REV / 360;
    localparam int CB2A  = 215 * REV / 360, CB2B = 225 * REV / 360;
    localparam int CB3A  = 280 * REV / 360, CB3B = 290 * REV / 360;
    localparam int LIGHT = 25 * REV / 360,  ANYD = 27 * REV / 360;
    localparam int COL0  = 30 * REV / 360,  DARK = 211 * REV / 360;
    localparam int GATE  = CB3B + 1000;
    localparam int PER   = 157, NCOL = 80;
    localparam int COLEND = COL0 + NCOL * PER;
    localparam logic [11:0] MASK = 12'h0A5;

    logic clk = 0, rst_n = 0;
    logic feed_mag = 0, card_ready = 0, fifo_full = 0, read_done = 0;
    logic rderr_pend = 0, fderr_pend = 0;
    logic [11:0] fifo_word = '0;
    logic cb1, cb2, cb3, emit, lever, fifo_pop;
    logic [11:0] cells;

    feed_wheel dut (.*);

    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0, errors = 0;
    bit done = 0;
    int q[$];

    // reference state
    int a = GATE, passes = 0;
    bit frz = 0, cf = 0, cr = 0, crd = 0, cfd = 0, lev = 0;
    logic [11:0] word = '0;
    int emit_rises = 0, pop_cnt = 0, cb1_rises = 0, lever_rises = 0;
    logic p_emit = 0, p_cb1 = 0, p_lev = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load_card(input int seed);
        for (int i = 0; i < NCOL; i++) q.push_back((i * 97 + seed * 13) % 4096);
    endtask

    task automatic step();
        bit incol, hold, e_cb1, e_cb2, e_cb3, e_emit, e_pop, n_lev;
        int off, col, ph;
        logic [11:0] e_cells, n_word;
        @(negedge clk);
        incol = cf && a >= COL0 && a < COLEND;
        off = a - COL0; col = off / PER; ph = off % PER;
        e_cb1 = a >= CB1A && a < CB1B;
        e_cb2 = a >= CB2A && a < CB2B;
        e_cb3 = a >= CB3A && a < CB3B;
        e_emit = incol && ph >= 20 && ph < 32;
        e_pop = incol && cr && ph == 32;
        n_word = (incol && cr && ph == 12) ? fifo_word : word;
        e_cells = '0;
        if (cf && cr && a >= ANYD && a < COL0) e_cells = 12'h001;
        if (incol && cr && ph >= 12 && ph <= 32) begin
            e_cells = ~n_word;
            if (crd && col == NCOL - 1 && ph > 20) e_cells = e_cells ^ MASK;
        end
        if (cf && cfd && e_cb2) e_cells = '1;
        n_lev = lev;
        if (cf && a == LIGHT) n_lev = 0;
        if (cf && a == DARK && fifo_full) n_lev = 1;

        chk({cb1, cb2, cb3} == {e_cb1, e_cb2, e_cb3}, "R1,R3,R4 cams", {cb1, cb2, cb3}, {e_cb1, e_cb2, e_cb3});
        chk(emit == e_emit, "R2 emitter", emit, e_emit);
        chk(fifo_pop == e_pop, "R6 pop", fifo_pop, e_pop);
        chk(lever == n_lev, "R5 lever", lever, n_lev);
        chk(cells == e_cells, "R6 cells", cells, e_cells);
        if (cf && cr && a == ANYD + 5) chk(cells == 12'h001, "R7 any-dark cell", cells, 1);
        if (incol && crd && col == NCOL - 1 && ph == 25)
            chk(cells == (cr ? ((~word) ^ MASK) : 12'h000), "R8 read fault replay", cells,
                cr ? ((~word) ^ MASK) : 0);
        if (cf && cfd && a == CB2A + 3) chk(cells == 12'hFFF, "R9 feed fault dark", cells, 12'hFFF);

        if (emit && !p_emit) emit_rises++;
        if (cb1 && !p_cb1) cb1_rises++;
        if (lever && !p_lev) lever_rises++;
        p_emit = emit; p_cb1 = cb1; p_lev = lever;

        // advance reference
        word = n_word; lev = n_lev;
        if (a == GATE) begin
            hold = (frz || (feed_mag && card_ready && !fifo_full)) && !read_done;
            if (hold) frz = 1;
            else begin
                frz = 0; cf = feed_mag; cr = lev_prev_capture(); crd = rderr_pend; cfd = fderr_pend;
                a = a + 1; passes++;
            end
        end else a = (a + 1) % REV;

        // bench-side buffer
        if (fifo_pop) begin
            pop_cnt++;
            if (q.size() > 0) void'(q.pop_front());
            if (q.size() == 0 && passes == 2) load_card(passes);
        end
        fifo_word = (q.size() > 0) ? 12'(q[0]) : '0;
        fifo_full = (q.size() > 0);
    endtask

    // lever value seen by the capture edge (before this edge's update)
    bit lev_at_edge;
    function automatic bit lev_prev_capture();
        return lev_at_edge;
    endfunction
    always @(posedge clk) lev_at_edge <= lever;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        #1;
        chk({cb1, cb2, cb3, emit, lever, fifo_pop} == 6'b0 && cells == 0, "R10 reset outputs",
            {cb1, cb2, cb3, emit, lever, fifo_pop}, 0);
        // run-in: feed with a physical card ready and empty buffer
        feed_mag = 1; card_ready = 1;
        repeat (40) step();
        chk(!cb1 && !cb2 && !cb3 && !emit, "R3 frozen wheel silent", {cb1, cb2, cb3, emit}, 0);
        chk(passes == 0, "R3 no departure while frozen", passes, 0);
        read_done = 1; load_card(1);
        fifo_word = 12'(q[0]); fifo_full = 1;
        step();
        read_done = 0;
        chk(passes == 1, "R4 release on read_done", passes, 1);
        while (passes < 5) begin
            step();
            if (a == GATE - 10) begin
                case (passes)
                    1: begin rderr_pend = 0; fderr_pend = 0; end
                    2: begin rderr_pend = 1; fderr_pend = 1; end
                    3: begin card_ready = 0; rderr_pend = 1; fderr_pend = 0; end
                    default: feed_mag = 0;
                endcase
            end
        end
        chk(cb1_rises == 4, "R1 one cb1 per revolution incl runout", cb1_rises, 4);
        chk(emit_rises == 4 * NCOL, "R2 emitter pulse count", emit_rises, 4 * NCOL);
        chk(pop_cnt == 2 * NCOL, "R6 pops on card cycles only", pop_cnt, 2 * NCOL);
        chk(lever_rises == 2, "R5 lever rises only with loaded buffer", lever_rises, 2);
        chk(lever == 0, "R5 lever off after runout", lever, 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R4 run did not complete actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule